// File: doc/BRIEF.md
# Interrupt pending and enable register pair

This block gathers interrupt requests from a set of peripheral sources into a pending register and holds an enable register that chooses which pending sources may reach the processor. Both registers sit in a small I/O page and are reached over a plain register bus with an address, write data, an access-size flag and a write strobe. Reads are combinational from the addressed register.

A request pulse on any source line latches the matching pending bit. Software clears pending bits by writing zeros into them. Ones in the write data leave those bits as they are. When a request and a clearing write hit the same bit in the same cycle, the request wins. The single processor interrupt output is high whenever a pending bit is also enabled. A write to the enable register is judged against pending bits at once, so enabling an already pending source raises the output on that same edge.

Top module: `irq_stat_mask_ctrl`

## Requirements
- R1: After reset, the pending register, the enable register and `cpu_irq` are all zero.
- R2: A high level on `src_req[i]` at a clock edge sets pending bit i at that edge. The bit stays set after the request drops. Source index 3 carries the DMA request and index 9 the sound request.
- R3: A write to offset 0x070 replaces the pending register with (old pending AND write data). A bit written 0 is cleared and a bit written 1 is unchanged. Pending bits never clear without such a write.
- R4: If a request and a write that clears the same pending bit occur in the same cycle, the bit stays set.
- R5: A write to offset 0x074 stores the write data in the enable register, and a read of 0x074 returns it. The register holds its value when not written.
- R6: `cpu_irq` equals the OR of (pending AND enable), and it changes on the same edge as the register write or request that alters that result.
- R7: With `bus_wide`=0 (16-bit access), writes use only `bus_wdata[15:0]` and leave register bits 16 and up unchanged, and reads return zero in `bus_rdata[31:16]`. With `bus_wide`=1 (32-bit access), all 32 bits take part.
- R8: Each register implements only NUM_SRC bits (11 by default). Higher bits read as zero. Writes to any other offset change neither register, and reads of other offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (12) | Byte offset within the I/O page |
| bus_wdata | input | 32 | Write data |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data of the addressed register |
| src_req | input | NUM_SRC (11) | Source request lines, one per pending bit |
| cpu_irq | output | 1 | Interrupt output to the processor |

## Verification
The assertions check on every cycle that requests set their bits, that pending bits clear only under a status write and then as the AND of old value and data, that a simultaneous request beats the acknowledge, that the enable register changes only when written, and that the output tracks the enabled pending set. Only the bench scenarios can show the byte offsets seen from the bus, the read-back values with unimplemented bits at zero, the 16-bit lane handling, and that stray offsets are ignored.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int BUS_W = 32;
  localparam int HALF_W = BUS_W / 2;

  // Merge a write into an old value according to the access size.
  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old_v,
                                                  input logic [BUS_W-1:0] wd,
                                                  input logic wide);
    return wide ? wd : {old_v[BUS_W-1:HALF_W], wd[HALF_W-1:0]};
  endfunction

  // Present a register value on the bus according to the access size.
  function automatic logic [BUS_W-1:0] read_lane(input logic [BUS_W-1:0] v,
                                                 input logic wide);
    return wide ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  // Acknowledge-by-AND with request priority.
  function automatic logic ack_bit(input logic old_b, input logic and_b, input logic req_b);
    return (old_b & and_b) | req_b;
  endfunction
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h074
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              hit_stat,
  output logic              hit_mask,
  output logic              wr_stat,
  output logic              wr_mask
);
  assign hit_stat = (addr == STAT_OFS);
  assign hit_mask = (addr == MASK_OFS);
  assign wr_stat  = we & hit_stat;
  assign wr_mask  = we & hit_mask;
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [NUM_SRC-1:0] and_val,
  input  logic [NUM_SRC-1:0] req,
  output logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] status_nxt
);
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    assign status_nxt[b] = ack_bit(status_q[b], wr ? and_val[b] : 1'b1, req[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_nxt;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [NUM_SRC-1:0] wval,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] mask_nxt
);
  assign mask_nxt = wr ? wval : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nxt;
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_nxt,
  input  logic [NUM_SRC-1:0] mask_nxt,
  output logic               irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_nxt & mask_nxt);
  end
endmodule

// File: rtl/irq_stat_mask_ctrl.sv
module irq_stat_mask_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h074
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_wide,
  input  logic               bus_we,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_req,
  output logic               cpu_irq
);
  logic hit_stat, hit_mask, wr_stat, wr_mask;
  logic [NUM_SRC-1:0] status_q, status_nxt, mask_q, mask_nxt;
  logic [NUM_SRC-1:0] stat_andv, mask_wval;

  irq_addr_dec #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_dec (
    .addr(bus_addr), .we(bus_we),
    .hit_stat(hit_stat), .hit_mask(hit_mask),
    .wr_stat(wr_stat), .wr_mask(wr_mask)
  );

  // 16-bit status writes keep the upper half by ANDing it with ones.
  assign stat_andv = NUM_SRC'(lane_merge({BUS_W{1'b1}}, bus_wdata, bus_wide));
  assign mask_wval = NUM_SRC'(lane_merge(BUS_W'(mask_q), bus_wdata, bus_wide));

  irq_stat_bank #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr(wr_stat), .and_val(stat_andv), .req(src_req),
    .status_q(status_q), .status_nxt(status_nxt)
  );

  irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(wr_mask), .wval(mask_wval),
    .mask_q(mask_q), .mask_nxt(mask_nxt)
  );

  irq_out_stage #(.NUM_SRC(NUM_SRC)) u_out (
    .clk(clk), .rst_n(rst_n), .status_nxt(status_nxt), .mask_nxt(mask_nxt),
    .irq_q(cpu_irq)
  );

  always_comb begin
    if (hit_stat)      bus_rdata = read_lane(BUS_W'(status_q), bus_wide);
    else if (hit_mask) bus_rdata = read_lane(BUS_W'(mask_q), bus_wide);
    else               bus_rdata = '0;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_SRC = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_req,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] stat_andv,
  input logic [NUM_SRC-1:0] mask_wval,
  input logic               wr_stat,
  input logic               wr_mask,
  input logic               cpu_irq
);
  p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req) |=> ((status & $past(src_req)) == $past(src_req)));

  p_ack_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !(|src_req)) |=> (status == ($past(status) & $past(stat_andv))));

  p_no_stray_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> (($past(status) & ~status) == '0));

  p_req_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && (|src_req)) |=> ((status & $past(src_req)) == $past(src_req)));

  p_mask_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask == $past(mask_wval)));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask));

  p_irq_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (|(status & mask)));
endmodule

bind irq_stat_mask_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .status(status_q), .mask(mask_q),
  .stat_andv(stat_andv), .mask_wval(mask_wval), .wr_stat(wr_stat), .wr_mask(wr_mask),
  .cpu_irq(cpu_irq)
);

// File: tb/irq_stat_mask_ctrl_tb.sv
module irq_stat_mask_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 11;
  localparam logic [11:0] A_ST = 12'h070;
  localparam logic [11:0] A_MK = 12'h074;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_wide = 1'b1;
  logic bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [NSRC-1:0] src_req = '0;
  logic cpu_irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_stat_mask_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wide(bus_wide), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .src_req(src_req), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // One write cycle; the result is visible at the following negedge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic wide,
                    input logic [NSRC-1:0] req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wide = wide; bus_we = 1'b1; src_req = req;
    @(negedge clk);
    bus_we = 1'b0; src_req = '0; bus_wide = 1'b1;
  endtask

  task automatic pulse(input logic [NSRC-1:0] req);
    @(negedge clk); src_req = req;
    @(negedge clk); src_req = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic wide, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wide = wide;
    #1 v = bus_rdata;
    bus_wide = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_ST, 1'b1, v); check("R1 status", v, 32'h0);
    rd(A_MK, 1'b1, v); check("R1 mask", v, 32'h0);
    check("R1 irq", 32'(cpu_irq), 32'h0);
  endtask

  task automatic t_requests();
    logic [31:0] v;
    pulse(11'h008);
    rd(A_ST, 1'b1, v); check("R2 dma bit3", v, 32'h008);
    pulse(11'h200);
    rd(A_ST, 1'b1, v); check("R2 sound bit9 held with bit3", v, 32'h208);
    check("R6 irq low with mask clear", 32'(cpu_irq), 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(A_MK, 32'h0000_0200, 1'b1, '0);
    check("R6 irq rises on mask write edge", 32'(cpu_irq), 32'h1);
    rd(A_MK, 1'b1, v); check("R5 mask readback", v, 32'h200);
    wr(A_MK, 32'h0000_0000, 1'b1, '0);
    check("R6 irq drops with mask", 32'(cpu_irq), 32'h0);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(A_MK, 32'h0000_0208, 1'b1, '0);
    wr(A_ST, 32'hFFFF_FDFF, 1'b1, '0);
    rd(A_ST, 1'b1, v); check("R3 zero clears bit9", v, 32'h008);
    check("R6 irq still from bit3", 32'(cpu_irq), 32'h1);
    wr(A_ST, 32'hFFFF_FFFF, 1'b1, '0);
    rd(A_ST, 1'b1, v); check("R3 ones keep", v, 32'h008);
    wr(A_ST, 32'hFFFF_FFF7, 1'b1, '0);
    check("R6 irq drops on ack edge", 32'(cpu_irq), 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(A_ST, 32'h0, 1'b1, 11'h008);
    rd(A_ST, 1'b1, v); check("R4 request beats ack", v, 32'h008);
    wr(A_ST, 32'h0, 1'b1, '0);
    rd(A_ST, 1'b1, v); check("R3 all cleared", v, 32'h0);
  endtask

  task automatic t_width();
    logic [31:0] v;
    wr(A_MK, 32'hFFFF_0401, 1'b0, '0);
    rd(A_MK, 1'b1, v); check("R7 16-bit mask write", v, 32'h401);
    rd(A_MK, 1'b0, v); check("R7 16-bit read", v, 32'h401);
    pulse(11'h401);
    wr(A_ST, 32'hFFFF_FBFF, 1'b0, '0);
    rd(A_ST, 1'b0, v); check("R7 16-bit ack of bit10", v, 32'h001);
    check("R6 irq from bit0", 32'(cpu_irq), 32'h1);
    wr(A_ST, 32'h0000_FFFE, 1'b0, '0);
    rd(A_ST, 1'b1, v); check("R7 16-bit ack of bit0", v, 32'h0);
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    wr(A_MK, 32'hFFFF_FFFF, 1'b1, '0);
    rd(A_MK, 1'b1, v); check("R8 mask upper bits zero", v, 32'h7FF);
    pulse(11'h7FF);
    rd(A_ST, 1'b1, v); check("R8 status upper bits zero", v, 32'h7FF);
    wr(12'h078, 32'h0, 1'b1, '0);
    wr(12'h072, 32'h0, 1'b1, '0);
    rd(A_ST, 1'b1, v); check("R8 stray write leaves status", v, 32'h7FF);
    rd(A_MK, 1'b1, v); check("R8 stray write leaves mask", v, 32'h7FF);
    rd(12'h078, 1'b1, v); check("R8 stray read zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_requests();
    t_mask();
    t_ack();
    t_race();
    t_width();
    t_unimpl();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule